// File: doc/BRIEF.md
# Store Queue with Load Forwarding

This block buffers in-flight stores in a circular queue and lets executing loads take their data from an older store instead of from memory. Each store is first given a slot, which is its index at the tail. Its address, size and data arrive later through a separate write port. The store is then committed in program order, and finally drained to memory through a valid/ready handshake. A slot is freed only when its drain handshake completes. A commit does not free it.

A load presents its address, its size and a boundary index, which is the tail value seen when the load was dispatched. The block searches the stores older than that boundary, starting with the youngest and moving toward the oldest. The first store whose bytes overlap the load decides the result:
- If that store fully contains the load, the load data is forwarded in the same cycle.
- If it covers only part of the load, forwarding is refused, the queue stalls and the blocking store is recorded. When that store has drained, a one-cycle replay pulse tells the load to try again.
- If no older store overlaps, the load is a miss and goes to memory.

Top module: `store_fwd_queue`

## Requirements
- R1: `count` equals the number of allocated stores not yet drained. `full` is high when `count` is at least DEPTH-1. An allocation while `full` is high is ignored. `alloc_idx` shows the slot the next allocation takes, and it wraps modulo DEPTH.
- R2: A commit marks the oldest uncommitted store and does not change `count`. A slot is released only in the cycle after its drain handshake (`mem_valid` and `mem_ready` both high).
- R3: Stores drain in allocation order. `mem_valid` is high only when the oldest store is both committed and written. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R4: A lookup considers only written stores from index `ld_bound`-1 back to the oldest allocated store. The youngest overlapping store among them decides the result.
- R5: Size code s means 2^s bytes, and stores are naturally aligned. When the deciding store's byte range contains the whole load, `ld_hit` is high in the same cycle. `ld_data` then equals the store data shifted right by 8×(`ld_addr` AND (store bytes−1)), with the bits above the load size cleared.
- R6: When the deciding store overlaps the load only partly, `ld_partial` is high and `ld_hit` is low in the same cycle. If `ld_valid` is high in that cycle, `stall` rises after the next clock edge. When `ld_valid` is low, no stall is taken.
- R7: `stall` stays high through drains of other stores. It falls, and `replay` pulses for exactly one cycle, in the cycle after the blocking store's drain handshake.
- R8: When no considered store overlaps the load, both `ld_hit` and `ld_partial` are low.
- R9: After reset, `count`, `full`, `mem_valid`, `stall`, `replay` and `alloc_idx` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| alloc_valid | input | 1 | Allocate a slot at the tail |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| full | output | 1 | Queue full (count ≥ DEPTH-1) |
| count | output | IDX_W | Stores held |
| wr_valid | input | 1 | Write address, size and data into a slot |
| wr_idx | input | IDX_W | Slot written |
| wr_addr | input | ADDR_W | Store byte address |
| wr_size | input | 2 | Store size code (2^s bytes) |
| wr_data | input | DATA_W | Store data, low bytes significant |
| commit_valid | input | 1 | Commit the oldest uncommitted store |
| mem_valid | output | 1 | Oldest store ready to drain |
| mem_ready | input | 1 | Memory accepts the drain |
| mem_addr | output | ADDR_W | Drain address |
| mem_size | output | 2 | Drain size code |
| mem_data | output | DATA_W | Drain data |
| ld_valid | input | 1 | Load executes this cycle; may take a stall |
| ld_addr | input | ADDR_W | Load byte address |
| ld_size | input | 2 | Load size code |
| ld_bound | input | IDX_W | Tail index at load dispatch |
| ld_hit | output | 1 | Forwarding succeeds |
| ld_partial | output | 1 | Partial overlap, no forwarding |
| ld_data | output | DATA_W | Forwarded data |
| stall | output | 1 | Queue stalled on a partial overlap |
| replay | output | 1 | One-cycle pulse: replay the stalled load |

## Verification
Lookup results (`ld_hit`, `ld_partial`, `ld_data`) are combinational and are due in the cycle the load inputs are applied. The bench therefore changes those inputs shortly after a rising edge and samples them 1 ns later, with no edge in between. `count`, `full`, `alloc_idx`, `stall` and `replay` each pass through one register, so they are sampled just after the edge that follows the stimulus. `replay` is sampled only in the single cycle after the blocking store's handshake and is checked low again one edge later. Drain outputs are checked both while `mem_ready` is held low and after each handshake, which confirms that they hold and that drains happen in order.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int SQ_MAX_BYTES = 8;
  localparam int SQ_SIZE_W    = 2;
  typedef logic [SQ_SIZE_W-1:0] sq_size_t;

  function automatic int sq_bytes(input sq_size_t code);
    return 1 << code;
  endfunction
endpackage

// File: rtl/sq_ptrs.sv
module sq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_valid,
  input  logic             commit_valid,
  input  logic             wb_fire,
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] cptr,
  output logic             alloc_ok,
  output logic             commit_ok,
  output logic [IDX_W-1:0] count,
  output logic             full
);
  logic [IDX_W-1:0] head_d, tail_d, cptr_d;

  always_comb begin
    count     = tail - head;
    full      = count >= IDX_W'(DEPTH - 1);
    alloc_ok  = alloc_valid && !full;
    commit_ok = commit_valid && (cptr != tail);
    head_d    = wb_fire   ? head + 1'b1 : head;
    tail_d    = alloc_ok  ? tail + 1'b1 : tail;
    cptr_d    = commit_ok ? cptr + 1'b1 : cptr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
      cptr <= '0;
    end else begin
      head <= head_d;
      tail <= tail_d;
      cptr <= cptr_d;
    end
  end

  AST_COUNT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
    count <= IDX_W'(DEPTH - 1)); // R1
  AST_NO_ALLOC_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    full && !wb_fire |=> count == $past(count)); // R1
  AST_RELEASE_ON_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    !wb_fire |=> count >= $past(count)); // R2
  AST_COMMIT_BEHIND_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
    (cptr - head) <= count); // R2
endmodule

// File: rtl/sq_search.sv
module sq_search
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = SQ_MAX_BYTES * 8,
  localparam int AX_W   = ADDR_W + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [IDX_W-1:0]      head,
  input  logic [IDX_W-1:0]      bound,
  input  logic [ADDR_W-1:0]     ld_addr,
  input  sq_size_t              ld_size,
  input  logic [DEPTH-1:0]      st_ok,
  input  logic [ADDR_W-1:0]     st_addr [DEPTH],
  input  sq_size_t              st_size [DEPTH],
  input  logic [DATA_W-1:0]     st_data [DEPTH],
  output logic                  hit,
  output logic                  partial,
  output logic [IDX_W-1:0]      sel,
  output logic [DATA_W-1:0]     data
);
  logic [IDX_W-1:0] span;
  logic [DEPTH-1:0] ovl;
  logic             found;
  logic [AX_W-1:0]  ld_end;
  logic [AX_W-1:0]  st_end;
  logic             contain;
  logic [2:0]       off;
  logic [DATA_W-1:0] mask;

  // Per-slot overlap against the load range
  always_comb begin
    ld_end = AX_W'(ld_addr) + AX_W'(sq_bytes(ld_size));
    for (int i = 0; i < DEPTH; i++) begin
      ovl[i] = st_ok[i]
            && (AX_W'(ld_addr) < AX_W'(st_addr[i]) + AX_W'(sq_bytes(st_size[i])))
            && (AX_W'(st_addr[i]) < ld_end);
    end
  end

  // Youngest-first walk from bound-1 toward head
  always_comb begin
    span  = bound - head;
    found = 1'b0;
    sel   = '0;
    for (int k = 0; k < DEPTH - 1; k++) begin
      if (!found && (k < int'(span)) && ovl[bound - IDX_W'(1) - IDX_W'(k)]) begin
        found = 1'b1;
        sel   = bound - IDX_W'(1) - IDX_W'(k);
      end
    end
  end

  always_comb begin
    st_end  = AX_W'(st_addr[sel]) + AX_W'(sq_bytes(st_size[sel]));
    contain = (ld_addr >= st_addr[sel]) && (ld_end <= st_end);
    off     = ld_addr[2:0] & 3'(sq_bytes(st_size[sel]) - 1);
    mask    = (ld_size == sq_size_t'(3)) ? '1
            : ((DATA_W'(1) << (sq_bytes(ld_size) * 8)) - DATA_W'(1));
    hit     = found && contain;
    partial = found && !contain;
    data    = hit ? ((st_data[sel] >> (int'(off) * 8)) & mask) : '0;
  end

  AST_HIT_PARTIAL_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && partial)); // R5
  AST_NO_OVERLAP_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    (ovl == '0) |-> !hit && !partial); // R8
endmodule

// File: rtl/sq_stall.sv
module sq_stall #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             probe,
  input  logic [IDX_W-1:0] probe_idx,
  input  logic             wb_fire,
  input  logic [IDX_W-1:0] head,
  output logic             stall,
  output logic             replay
);
  logic             stall_d, replay_d;
  logic [IDX_W-1:0] blk_q, blk_d;
  logic             blk_drained;

  always_comb begin
    blk_drained = stall && wb_fire && (head == blk_q);
    stall_d     = stall;
    blk_d       = blk_q;
    replay_d    = 1'b0;
    if (stall) begin
      if (blk_drained) begin
        stall_d  = 1'b0;
        replay_d = 1'b1;
      end
    end else if (probe) begin
      stall_d = 1'b1;
      blk_d   = probe_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall  <= 1'b0;
      replay <= 1'b0;
      blk_q  <= '0;
    end else begin
      stall  <= stall_d;
      replay <= replay_d;
      if (!stall && probe) blk_q <= blk_d;
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    stall && !(wb_fire && head == blk_q) |=> stall); // R7
  AST_REPLAY_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    replay |-> !stall && $past(stall)); // R7
  AST_REPLAY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> !replay); // R7
  AST_STALL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stall) |-> $past(probe)); // R6
endmodule

// File: rtl/store_fwd_queue.sv
module store_fwd_queue
  import sq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = 16,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int DATA_W = SQ_MAX_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_valid,
  output logic [IDX_W-1:0]  alloc_idx,
  output logic              full,
  output logic [IDX_W-1:0]  count,
  input  logic              wr_valid,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [1:0]        wr_size,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit_valid,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_size,
  output logic [DATA_W-1:0] mem_data,
  input  logic              ld_valid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [1:0]        ld_size,
  input  logic [IDX_W-1:0]  ld_bound,
  output logic              ld_hit,
  output logic              ld_partial,
  output logic [DATA_W-1:0] ld_data,
  output logic              stall,
  output logic              replay
);
  logic [IDX_W-1:0]  head, tail, cptr, blk_sel;
  logic              alloc_ok, commit_ok, wb_fire;
  logic [DEPTH-1:0]  ok_q, ok_d, cm_q, cm_d;
  logic [ADDR_W-1:0] st_addr [DEPTH];
  sq_size_t          st_size [DEPTH];
  logic [DATA_W-1:0] st_data [DEPTH];

  initial begin
    if ((1 << IDX_W) != DEPTH) $error("DEPTH must be a power of two");
  end

  sq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
    .commit_valid(commit_valid), .wb_fire(wb_fire),
    .head(head), .tail(tail), .cptr(cptr), .alloc_ok(alloc_ok),
    .commit_ok(commit_ok), .count(count), .full(full)
  );

  // Entry flags: written (ok) and committed (cm)
  always_comb begin
    ok_d = ok_q;
    cm_d = cm_q;
    if (wr_valid)  ok_d[wr_idx] = 1'b1;
    if (commit_ok) cm_d[cptr]   = 1'b1;
    if (alloc_ok) begin
      ok_d[tail] = 1'b0;
      cm_d[tail] = 1'b0;
    end
    if (wb_fire) begin
      ok_d[head] = 1'b0;
      cm_d[head] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q <= '0;
      cm_q <= '0;
    end else begin
      ok_q <= ok_d;
      cm_q <= cm_d;
    end
  end

  // Payload storage, written only through the write port
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_valid && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        st_addr[g] <= wr_addr;
        st_size[g] <= wr_size;
        st_data[g] <= wr_data;
      end
    end
  end

  assign alloc_idx = tail;
  assign mem_valid = (count != '0) && ok_q[head] && cm_q[head];
  assign mem_addr  = st_addr[head];
  assign mem_size  = st_size[head];
  assign mem_data  = st_data[head];
  assign wb_fire   = mem_valid && mem_ready;

  sq_search #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_search (
    .clk(clk), .rst_n(rst_n), .head(head), .bound(ld_bound),
    .ld_addr(ld_addr), .ld_size(ld_size), .st_ok(ok_q),
    .st_addr(st_addr), .st_size(st_size), .st_data(st_data),
    .hit(ld_hit), .partial(ld_partial), .sel(blk_sel), .data(ld_data)
  );

  sq_stall #(.DEPTH(DEPTH)) u_stall (
    .clk(clk), .rst_n(rst_n), .probe(ld_valid && ld_partial),
    .probe_idx(blk_sel), .wb_fire(wb_fire), .head(head),
    .stall(stall), .replay(replay)
  );

  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_data)); // R3
  AST_DRAIN_COMMITTED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (cptr != head) || (count == IDX_W'(0))); // R3
endmodule

// File: tb/test_store_fwd_queue.sv
`timescale 1ns/1ps
module test_store_fwd_queue;
  localparam int DEPTH = 8;
  localparam int AW    = 16;
  localparam int IW    = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic alloc_valid, wr_valid, commit_valid, mem_ready, ld_valid;
  logic [IW-1:0] wr_idx, ld_bound, alloc_idx, count;
  logic [AW-1:0] wr_addr, ld_addr, mem_addr;
  logic [1:0]    wr_size, ld_size, mem_size;
  logic [63:0]   wr_data, mem_data, ld_data;
  logic full, mem_valid, ld_hit, ld_partial, stall, replay;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  localparam logic [63:0] D0 = 64'h8877665544332211;
  localparam logic [63:0] D1 = 64'h00000000D4C3B2A1;
  localparam logic [63:0] D2 = 64'h0123456789ABCDEF;

  always #2.5 clk = ~clk;

  store_fwd_queue #(.DEPTH(DEPTH), .ADDR_W(AW)) i_store_fwd_queue (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_idx(alloc_idx),
    .full(full), .count(count), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .commit_valid(commit_valid), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_size(mem_size), .mem_data(mem_data),
    .ld_valid(ld_valid), .ld_addr(ld_addr), .ld_size(ld_size),
    .ld_bound(ld_bound), .ld_hit(ld_hit), .ld_partial(ld_partial),
    .ld_data(ld_data), .stall(stall), .replay(replay)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic write_st(input int idx, input logic [AW-1:0] a,
                          input logic [1:0] s, input logic [63:0] d);
    wr_valid = 1'b1; wr_idx = IW'(idx); wr_addr = a; wr_size = s; wr_data = d;
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic look(input logic [AW-1:0] a, input logic [1:0] s,
                      input int bnd);
    ld_addr = a; ld_size = s; ld_bound = IW'(bnd);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    alloc_valid = 0; wr_valid = 0; commit_valid = 0; mem_ready = 0; ld_valid = 0;
    wr_idx = 0; wr_addr = 0; wr_size = 0; wr_data = 0;
    ld_addr = 0; ld_size = 0; ld_bound = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // R9 reset state
    chk("R9", "count", 64'(count), 0);
    chk("R9", "full", 64'(full), 0);
    chk("R9", "mem_valid", 64'(mem_valid), 0);
    chk("R9", "stall", 64'(stall), 0);
    chk("R9", "replay", 64'(replay), 0);
    chk("R9", "alloc_idx", 64'(alloc_idx), 0);

    // R1 allocate three slots
    alloc_valid = 1'b1;
    repeat (3) tick();
    alloc_valid = 1'b0;
    chk("R1", "count after 3 allocs", 64'(count), 3);
    chk("R1", "alloc_idx after 3 allocs", 64'(alloc_idx), 3);
    chk("R3", "no drain before commit", 64'(mem_valid), 0);

    write_st(0, 16'h0010, 2'd3, D0);
    write_st(1, 16'h0010, 2'd2, D1);
    write_st(2, 16'h0040, 2'd3, D2);

    // R5/R6/R8 sweep against the single older store (bound=1)
    for (int a = 16'h0008; a < 16'h0020; a++) begin
      for (int s = 0; s < 4; s++) begin
        int lb;
        bit ov, ct;
        logic [63:0] msk, exp_d;
        lb = 1 << s;
        ov = (a < 16'h0018) && (16'h0010 < a + lb);
        ct = (a >= 16'h0010) && (a + lb <= 16'h0018);
        msk = (lb == 8) ? '1 : ((64'h1 << (lb * 8)) - 1);
        exp_d = ct ? ((D0 >> ((a & 7) * 8)) & msk) : 64'h0;
        look(AW'(a), 2'(s), 1);
        chk(ct ? "R5" : (ov ? "R6" : "R8"), "sweep hit", 64'(ld_hit), 64'(ct));
        chk(ov && !ct ? "R6" : "R5", "sweep partial", 64'(ld_partial), 64'(ov && !ct));
        if (ct) chk("R5", "sweep data", ld_data, exp_d);
      end
    end
    tick();
    chk("R6", "no stall without ld_valid", 64'(stall), 0);

    // R4 youngest-first selection with bound=2
    look(16'h0012, 2'd1, 2);
    chk("R4", "younger store wins hit", 64'(ld_hit), 1);
    chk("R4", "younger store wins data", ld_data, 64'hD4C3);
    look(16'h0014, 2'd2, 2);
    chk("R4", "skip non-overlap younger", 64'(ld_hit), 1);
    chk("R4", "older store data", ld_data, 64'h88776655);
    look(16'h0010, 2'd3, 2);
    chk("R4", "younger partial decides", 64'(ld_partial), 1);
    look(16'h0010, 2'd3, 0);
    chk("R4", "empty range miss", 64'(ld_hit | ld_partial), 0);
    look(16'h0044, 2'd1, 3);
    chk("R5", "third store data", ld_data, 64'h4567);

    // R6 take a stall on store 1
    look(16'h0010, 2'd3, 2);
    ld_valid = 1'b1;
    tick();
    ld_valid = 1'b0;
    chk("R6", "stall raised", 64'(stall), 1);

    // R2 commit does not release
    commit_valid = 1'b1;
    repeat (3) tick();
    commit_valid = 1'b0;
    chk("R2", "count after commits", 64'(count), 3);
    chk("R3", "drain valid", 64'(mem_valid), 1);
    chk("R3", "drain addr st0", 64'(mem_addr), 64'h10);
    chk("R3", "drain data st0", mem_data, D0);

    mem_ready = 1'b1;
    tick();
    mem_ready = 1'b0;
    chk("R2", "count after one drain", 64'(count), 2);
    chk("R7", "stall holds on other drain", 64'(stall), 1);
    chk("R7", "no replay on other drain", 64'(replay), 0);
    chk("R3", "in-order drain addr", 64'(mem_addr), 64'h10);
    chk("R3", "in-order drain data", mem_data, D1);
    tick();
    chk("R3", "hold while not ready", mem_data, D1);
    chk("R7", "stall still high", 64'(stall), 1);

    mem_ready = 1'b1;
    tick();
    mem_ready = 1'b0;
    chk("R7", "replay pulse", 64'(replay), 1);
    chk("R7", "stall cleared", 64'(stall), 0);
    chk("R2", "count after blocker drain", 64'(count), 1);
    tick();
    chk("R7", "replay one cycle", 64'(replay), 0);

    // R1 fill with wrap
    alloc_valid = 1'b1;
    repeat (6) tick();
    chk("R1", "full at DEPTH-1", 64'(full), 1);
    chk("R1", "count full", 64'(count), 7);
    chk("R1", "alloc_idx wrapped", 64'(alloc_idx), 1);
    tick();
    alloc_valid = 1'b0;
    chk("R1", "alloc ignored when full", 64'(count), 7);
    chk("R1", "tail unchanged when full", 64'(alloc_idx), 1);

    mem_ready = 1'b1;
    chk("R3", "drain st2 addr", 64'(mem_addr), 64'h40);
    tick();
    mem_ready = 1'b0;
    chk("R2", "release after drain", 64'(count), 6);
    chk("R1", "full drops", 64'(full), 0);
    chk("R3", "uncommitted not drained", 64'(mem_valid), 0);

    // R4 search across the wrap point
    write_st(0, 16'h0020, 2'd1, 64'h000000000000BEEF);
    look(16'h0020, 2'd1, 1);
    chk("R4", "wrapped hit", 64'(ld_hit), 1);
    chk("R4", "wrapped data", ld_data, 64'hBEEF);
    look(16'h0040, 2'd3, 1);
    chk("R8", "drained store not found", 64'(ld_hit | ld_partial), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule